// File: doc/BRIEF.md
# Cascaded Interrupt Status Controller

This block collects interrupt events for a USB device controller into one 32-bit status register. Each event source sends a single-cycle pulse, and the pulse sets a sticky status bit. The sources are the bus-state detectors and one receive and one transmit line for each endpoint buffer. The DMA engine gets a single summary bit in the status register. The individual DMA causes sit in a second register, the DMA reason register, which the summary bit is built from.

A host microprocessor reads either register through a small register port. It clears bits by writing ones, and a write of zero changes nothing. A DMA interrupt is only fully gone once the host has cleared the bit in the reason register and then the summary bit as well. If the host clears the summary bit while a reason is still pending, the summary bit comes back. The level interrupt output `irq_o` is high whenever the status register holds anything.

Top module: `irq_status_ctrl`

## Requirements
- R1: A pulse on `bus_evt_i[k]` sets status bit k, and the bit reads back from the cycle after the pulse. The mapping is bit 0 bus reset, bit 1 start-of-frame, bit 2 pseudo start-of-frame, bit 3 suspend and bit 4 resume.
- R2: A pulse on `ep_rx_evt_i[n]` sets status bit 8+2n. A pulse on `ep_tx_evt_i[n]` sets status bit 9+2n. n runs over the endpoints 0..NUM_EP-1.
- R3: A write with `reg_addr_i`=0 clears every status bit whose `reg_wdata_i` bit is 1, from the next cycle on. Bits written with 0 keep their value.
- R4: If an event pulse and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R5: Status bits 5, 6 and every bit above 8+2*NUM_EP-1 always read 0.
- R6: A pulse on `dma_evt_i[k]` sets reason bit k. The reason register reads back zero-extended at `reg_addr_i`=1. A write to `reg_addr_i`=1 clears the reason bits written with 1, and set wins over clear as in R4.
- R7: Status bit 7 (DMA summary) is set the cycle after any `dma_evt_i` pulse.
- R8: If the summary bit is cleared while the reason register is nonzero, bit 7 reads 0 for one cycle and then reads 1 again. If the reason register is cleared first and the summary bit after it, bit 7 stays 0.
- R9: `irq_o` is 1 exactly when the status register is nonzero.
- R10: While `rst_ni` is low, both registers read 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_evt_i | input | 5 | Bus-state event pulses, one per status bit 0..4 |
| ep_rx_evt_i | input | NUM_EP | Endpoint receive event pulses |
| ep_tx_evt_i | input | NUM_EP | Endpoint transmit event pulses |
| dma_evt_i | input | DMA_RW | DMA cause pulses, one per reason bit |
| reg_wr_i | input | 1 | Write strobe (write-one-to-clear) |
| reg_addr_i | input | 1 | Register select: 0 status, 1 DMA reason |
| reg_wdata_i | input | 32 | Write data, a 1 clears the matching bit |
| reg_rdata_o | output | 32 | Read data for the selected register |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench goes after three collisions:
- An event and a clear landing on the same bit in one cycle. A design that gives the clear priority loses that event and reads 0.
- The summary bit being cleared while a reason is still pending. A design that drops the reason dependency leaves bit 7 at 0 with a cause outstanding. A design with no one-cycle gap shows 1 where 0 is expected.
- The correct two-write order. A design that re-sets bit 7 without looking at the reason register brings it back after the correct order.

The bench also writes all ones and fires every source at once. This exposes any bit that should not exist and any endpoint pair wired to the wrong bit.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int STAT_W      = 32;
  localparam int BUS_EVT_N   = 5;
  localparam int BIT_BUS_RST = 0;
  localparam int BIT_SOF     = 1;
  localparam int BIT_PSOF    = 2;
  localparam int BIT_SUSP    = 3;
  localparam int BIT_RESUME  = 4;
  localparam int BIT_DMA     = 7;
  localparam int EP_BASE     = 8;
  localparam int EP_MAX      = (STAT_W - EP_BASE) / 2;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_REASON = 1'b1
  } reg_sel_e;

  // implemented status bits for a given endpoint count
  function automatic logic [STAT_W-1:0] stat_mask(int num_ep);
    logic [STAT_W-1:0] m;
    m = '0;
    for (int b = 0; b < BUS_EVT_N; b++) m[b] = 1'b1;
    m[BIT_DMA] = 1'b1;
    for (int n = 0; n < EP_MAX; n++) begin
      if (n < num_ep) begin
        m[EP_BASE + 2*n]     = 1'b1;
        m[EP_BASE + 2*n + 1] = 1'b1;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/irq_w1c_reg.sv
module irq_w1c_reg #(
  parameter int          W    = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;

  // set dominates clear so a colliding event survives
  always_comb q_d = ((q_q & ~clr_i) | set_i) & MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/irq_dma_reason.sv
module irq_dma_reason #(
  parameter int RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] evt_i,
  input  logic [RW-1:0] clr_i,
  input  logic          sum_q_i,
  output logic [RW-1:0] reason_o,
  output logic          sum_set_o
);
  logic [RW-1:0] reason_q;

  irq_w1c_reg #(.W(RW), .MASK({RW{1'b1}})) u_reason (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_i),
    .clr_i  (clr_i),
    .q_o    (reason_q)
  );

  // fresh cause, or a pending cause left behind after the summary was cleared
  assign sum_set_o = (|evt_i) | ((|reason_q) & ~sum_q_i);
  assign reason_o  = reason_q;
endmodule

// File: rtl/irq_src_map.sv
module irq_src_map
  import irq_pkg::*;
#(
  parameter int NUM_EP = 8
) (
  input  logic [BUS_EVT_N-1:0] bus_evt_i,
  input  logic [NUM_EP-1:0]    ep_rx_evt_i,
  input  logic [NUM_EP-1:0]    ep_tx_evt_i,
  input  logic                 dma_set_i,
  output logic [STAT_W-1:0]    set_o
);
  always_comb begin
    set_o = '0;
    set_o[BIT_BUS_RST] = bus_evt_i[BIT_BUS_RST];
    set_o[BIT_SOF]     = bus_evt_i[BIT_SOF];
    set_o[BIT_PSOF]    = bus_evt_i[BIT_PSOF];
    set_o[BIT_SUSP]    = bus_evt_i[BIT_SUSP];
    set_o[BIT_RESUME]  = bus_evt_i[BIT_RESUME];
    set_o[BIT_DMA]     = dma_set_i;
    for (int n = 0; n < NUM_EP; n++) begin
      set_o[EP_BASE + 2*n]     = ep_rx_evt_i[n];
      set_o[EP_BASE + 2*n + 1] = ep_tx_evt_i[n];
    end
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_EP = 8,
  parameter int DMA_RW = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [BUS_EVT_N-1:0] bus_evt_i,
  input  logic [NUM_EP-1:0]    ep_rx_evt_i,
  input  logic [NUM_EP-1:0]    ep_tx_evt_i,
  input  logic [DMA_RW-1:0]    dma_evt_i,
  input  logic                 reg_wr_i,
  input  logic                 reg_addr_i,
  input  logic [STAT_W-1:0]    reg_wdata_i,
  output logic [STAT_W-1:0]    reg_rdata_o,
  output logic                 irq_o
);
  localparam logic [STAT_W-1:0] STAT_MASK = stat_mask(NUM_EP);

  initial begin
    if (NUM_EP < 1 || NUM_EP > EP_MAX) $error("NUM_EP out of range");
    if (DMA_RW < 1 || DMA_RW > STAT_W) $error("DMA_RW out of range");
  end

  reg_sel_e            sel;
  logic [STAT_W-1:0]   clr_stat;
  logic [DMA_RW-1:0]   clr_reason;
  logic [STAT_W-1:0]   set_stat;
  logic [STAT_W-1:0]   status_q;
  logic [DMA_RW-1:0]   reason_q;
  logic                dma_set;
  logic [STAT_W-1:0]   reason_ext;

  assign sel = reg_sel_e'(reg_addr_i);

  always_comb begin
    clr_stat   = '0;
    clr_reason = '0;
    if (reg_wr_i) begin
      if (sel == SEL_STATUS) clr_stat   = reg_wdata_i;
      else                   clr_reason = reg_wdata_i[DMA_RW-1:0];
    end
  end

  irq_dma_reason #(.RW(DMA_RW)) u_dma (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (dma_evt_i),
    .clr_i     (clr_reason),
    .sum_q_i   (status_q[BIT_DMA]),
    .reason_o  (reason_q),
    .sum_set_o (dma_set)
  );

  irq_src_map #(.NUM_EP(NUM_EP)) u_map (
    .bus_evt_i   (bus_evt_i),
    .ep_rx_evt_i (ep_rx_evt_i),
    .ep_tx_evt_i (ep_tx_evt_i),
    .dma_set_i   (dma_set),
    .set_o       (set_stat)
  );

  irq_w1c_reg #(.W(STAT_W), .MASK(STAT_MASK)) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_stat),
    .clr_i  (clr_stat),
    .q_o    (status_q)
  );

  always_comb begin
    reason_ext = '0;
    reason_ext[DMA_RW-1:0] = reason_q;
  end

  assign reg_rdata_o = (sel == SEL_REASON) ? reason_ext : status_q;
  assign irq_o       = |status_q;
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk
  import irq_pkg::*;
#(
  parameter int NUM_EP = 8,
  parameter int DMA_RW = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [BUS_EVT_N-1:0] bus_evt_i,
  input logic [NUM_EP-1:0]    ep_rx_evt_i,
  input logic [NUM_EP-1:0]    ep_tx_evt_i,
  input logic [DMA_RW-1:0]    dma_evt_i,
  input logic                 reg_wr_i,
  input logic                 reg_addr_i,
  input logic [STAT_W-1:0]    reg_wdata_i,
  input logic [STAT_W-1:0]    reg_rdata_o,
  input logic                 irq_o,
  input logic [STAT_W-1:0]    status_q,
  input logic [DMA_RW-1:0]    reason_q
);
  localparam logic [STAT_W-1:0] STAT_MASK = stat_mask(NUM_EP);

  logic wr_stat, wr_rsn, any_src;
  assign wr_stat = reg_wr_i && (reg_addr_i == SEL_STATUS);
  assign wr_rsn  = reg_wr_i && (reg_addr_i == SEL_REASON);
  assign any_src = (|bus_evt_i) | (|ep_rx_evt_i) | (|ep_tx_evt_i) | (|dma_evt_i) | (|reason_q);

  for (genvar k = 0; k < BUS_EVT_N; k++) begin : g_bus
    assert_bus_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_evt_i[k] |=> status_q[k]);
  end

  for (genvar n = 0; n < NUM_EP; n++) begin : g_ep
    assert_ep_rx_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ep_rx_evt_i[n] |=> status_q[EP_BASE + 2*n]);
    assert_ep_tx_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ep_tx_evt_i[n] |=> status_q[EP_BASE + 2*n + 1]);
  end

  assert_w1c_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && !any_src) |=> ((status_q & $past(reg_wdata_i)) == '0));

  assert_unused_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q & ~STAT_MASK) == '0);

  for (genvar k = 0; k < DMA_RW; k++) begin : g_rsn
    assert_reason_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dma_evt_i[k] |=> reason_q[k]);
    assert_reason_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reason_q[k] && !wr_rsn) |=> reason_q[k]);
  end

  assert_dma_sum_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dma_evt_i) |=> status_q[BIT_DMA]);

  assert_dma_rearm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q[BIT_DMA] && wr_stat && reg_wdata_i[BIT_DMA] && (|reason_q)
     && !wr_rsn && !(|dma_evt_i))
    |=> !status_q[BIT_DMA] ##1 status_q[BIT_DMA]);

  assert_irq_level_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == SEL_STATUS) |-> (irq_o == (reg_rdata_o != '0)));
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.NUM_EP(NUM_EP), .DMA_RW(DMA_RW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_evt_i   (bus_evt_i),
  .ep_rx_evt_i (ep_rx_evt_i),
  .ep_tx_evt_i (ep_tx_evt_i),
  .dma_evt_i   (dma_evt_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .status_q    (status_q),
  .reason_q    (reason_q)
);

// File: tb/irq_status_ctrl_bench.sv
module irq_status_ctrl_bench;
  localparam int NUM_EP = 8;
  localparam int DMA_RW = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [4:0]        bus_evt_i = '0;
  logic [NUM_EP-1:0] ep_rx_evt_i = '0;
  logic [NUM_EP-1:0] ep_tx_evt_i = '0;
  logic [DMA_RW-1:0] dma_evt_i = '0;
  logic              reg_wr_i = 1'b0;
  logic              reg_addr_i = 1'b0;
  logic [31:0]       reg_wdata_i = '0;
  logic [31:0]       reg_rdata_o;
  logic              irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] m_stat = '0;
  logic [31:0] m_rsn  = '0;
  logic [31:0] m_mask;

  always #10 clk_i = ~clk_i;

  irq_status_ctrl #(.NUM_EP(NUM_EP), .DMA_RW(DMA_RW)) u_irq_status_ctrl (
    .clk_i, .rst_ni, .bus_evt_i, .ep_rx_evt_i, .ep_tx_evt_i, .dma_evt_i,
    .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o, .irq_o
  );

  task automatic chk32(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  // peek both registers and the irq line; no write during the peek
  task automatic observe(string tag);
    reg_wr_i = 1'b0;
    reg_addr_i = 1'b0;
    #1 chk32(tag, "status", reg_rdata_o, m_stat);
    chk32({tag, "/R9"}, "irq", {31'b0, irq_o}, {31'b0, m_stat != 0});
    reg_addr_i = 1'b1;
    #1 chk32(tag, "reason", reg_rdata_o, m_rsn);
  endtask

  task automatic step(string tag, logic [4:0] bus, logic [NUM_EP-1:0] rx,
                      logic [NUM_EP-1:0] tx, logic [DMA_RW-1:0] dma,
                      logic wr, logic addr, logic [31:0] wd);
    logic [31:0] set, clr_s, clr_r;
    observe(tag);
    bus_evt_i = bus; ep_rx_evt_i = rx; ep_tx_evt_i = tx; dma_evt_i = dma;
    reg_wr_i = wr; reg_addr_i = addr; reg_wdata_i = wd;
    set = {27'b0, bus};
    for (int n = 0; n < NUM_EP; n++) begin
      if (rx[n]) set[8 + 2*n] = 1'b1;
      if (tx[n]) set[9 + 2*n] = 1'b1;
    end
    if (dma != 0 || (m_rsn != 0 && !m_stat[7])) set[7] = 1'b1;
    clr_s = (wr && !addr) ? wd : 32'b0;
    clr_r = (wr && addr) ? wd : 32'b0;
    @(posedge clk_i);
    m_stat = ((m_stat & ~clr_s) | set) & m_mask;
    m_rsn  = (m_rsn & ~clr_r & 32'h0000_00FF) | {24'b0, dma};
    @(negedge clk_i);
    bus_evt_i = '0; ep_rx_evt_i = '0; ep_tx_evt_i = '0; dma_evt_i = '0;
    reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic idle(string tag);
    step(tag, '0, '0, '0, '0, 1'b0, 1'b0, '0);
  endtask

  task automatic wr_stat(string tag, logic [31:0] wd);
    step(tag, '0, '0, '0, '0, 1'b1, 1'b0, wd);
  endtask

  task automatic wr_rsn(string tag, logic [31:0] wd);
    step(tag, '0, '0, '0, '0, 1'b1, 1'b1, wd);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_mask = 32'h0000_009F;
    for (int n = 0; n < NUM_EP; n++) m_mask[8 + 2*n +: 2] = 2'b11;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    // R10: state during reset
    observe("R10");
    rst_ni = 1'b1;

    // R1: each bus event
    for (int k = 0; k < 5; k++) step("R1", 5'(1 << k), '0, '0, '0, 1'b0, 1'b0, '0);
    idle("R1");
    wr_stat("R3", 32'h0000_001F);
    idle("R3");

    // R2: endpoint pairs
    step("R2", '0, 8'h08, 8'h20, '0, 1'b0, 1'b0, '0);
    step("R2", '0, 8'h01, 8'h80, '0, 1'b0, 1'b0, '0);
    step("R2", '0, 8'h80, 8'h01, '0, 1'b0, 1'b0, '0);
    idle("R2");
    wr_stat("R3", 32'hFFFF_FF00);
    idle("R3");

    // R3: write zero keeps, write ones clears
    step("R3", 5'h1F, '0, '0, '0, 1'b0, 1'b0, '0);
    wr_stat("R3", 32'h0000_0000);
    wr_stat("R3", 32'h0000_0005);
    idle("R3");
    wr_stat("R3", 32'h0000_001A);
    idle("R3");

    // R4: set wins over clear on the same bit
    step("R4", 5'h02, '0, '0, '0, 1'b0, 1'b0, '0);
    step("R4", 5'h02, '0, '0, '0, 1'b1, 1'b0, 32'h0000_0002);
    step("R4", '0, 8'h04, '0, '0, 1'b1, 1'b0, 32'h0000_1002);
    idle("R4");
    wr_stat("R4", 32'hFFFF_FFFF);
    idle("R4");

    // R5: every source at once, unused bits stay 0
    step("R5", 5'h1F, '1, '1, '1, 1'b0, 1'b0, '0);
    idle("R5");
    wr_rsn("R6", 32'hFFFF_FFFF);
    wr_stat("R5", 32'hFFFF_FFFF);
    idle("R5");

    // R6 / R7: reason bits and summary
    step("R6", '0, '0, '0, 8'h05, 1'b0, 1'b0, '0);
    idle("R7");
    wr_rsn("R6", 32'h0000_0001);
    step("R6", '0, '0, '0, 8'h04, 1'b1, 1'b1, 32'h0000_0004);
    idle("R6");

    // R8: clear summary with reason pending, then the correct order
    wr_stat("R8", 32'h0000_0080);
    idle("R8");
    idle("R8");
    wr_rsn("R8", 32'h0000_0004);
    wr_stat("R8", 32'h0000_0080);
    idle("R8");
    idle("R8");
    // R7: fresh cause during summary clear
    step("R7", '0, '0, '0, 8'h40, 1'b1, 1'b0, 32'h0000_0080);
    idle("R7");
    wr_rsn("R7", 32'h0000_0040);
    wr_stat("R7", 32'h0000_0080);
    idle("R9");

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step("mix", (r[3:0] == 0) ? 5'($urandom) : 5'b0,
           (r[7:4] == 0) ? 8'($urandom) : 8'b0,
           (r[11:8] == 0) ? 8'($urandom) : 8'b0,
           (r[15:12] == 0) ? 8'($urandom) : 8'b0,
           r[16], r[17], $urandom);
    end

    // R10: reset in mid-run
    step("R10", 5'h1F, '1, '1, '1, 1'b0, 1'b0, '0);
    rst_ni = 1'b0;
    m_stat = '0;
    m_rsn = '0;
    @(negedge clk_i);
    observe("R10");
    rst_ni = 1'b1;
    @(negedge clk_i);
    idle("R10");
    idle("R10");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule